// File: doc/BRIEF.md
# Hardware Signal Synchronization Unit

This block holds a small bank of signal objects for process synchronization. Each signal pairs an ordered queue of blocked process identifiers with a pending-send counter. A processor issues one command per cycle: SEND or WAIT on a signal index, or a scheduler pop on a processor's ready queue. One cycle later the unit answers with a response code. The code says whether a process was released and which one, whether the caller may proceed, or whether the caller must sleep.

The counter only carries meaning while the queue is empty. A send with no sleeper is banked in the counter, and a later wait consumes it. A wait that finds no banked send puts the caller at the tail of the queue. The upper group of signals, starting at `READY_BASE`, serves as one ready queue per processor. Processes are placed on a ready queue with an ordinary WAIT. The scheduler takes the oldest one with a pop command that carries the processor number. `NUM_SIG` and `QDEPTH` must be powers of two, and `READY_BASE + NUM_CPU` must not exceed `NUM_SIG`.

Top module: `sig_unit`

## Requirements
- R1: After reset `cmd_ready_o` is 1 and `rsp_valid_o` is 0. Every queue is empty and every counter is zero.
- R2: SEND (op 0) on a signal with a non-empty queue removes the oldest waiter. It responds RELEASED (code 1) with that waiter's id on `rsp_pid_o`, and waiters leave in arrival order.
- R3: SEND on a signal with an empty queue adds one to its counter and responds COUNTED (code 0).
- R4: WAIT (op 1) on a signal whose counter is non-zero subtracts one from the counter and responds CONTINUE (code 2).
- R5: WAIT on a signal whose counter is zero appends `cmd_pid_i` to the queue tail and responds BLOCKED (code 3).
- R6: POP-READY (op 2) with processor number c in `cmd_idx_i` acts on signal `READY_BASE + c`. If that queue holds a waiter, it removes the oldest and responds RELEASED (code 1) with its id. If the queue is empty, it responds EMPTY (code 4) and leaves the counter untouched.
- R7: WAIT on a signal whose counter is zero and whose queue already holds `QDEPTH` entries responds ERROR (code 5). The queue contents are unchanged.
- R8: The counter is `CNT_W` bits wide and saturates at 2^CNT_W-1. A SEND at that value still responds COUNTED and leaves the counter at its maximum.
- R9: A command is accepted on a clock edge where `cmd_valid_i` and `cmd_ready_o` are both 1. `rsp_valid_o` is 1 in exactly the cycle after an acceptance and 0 otherwise. An unaccepted command has no effect.
- R10: A command changes only the state of the signal it addresses.
- R11: POP-READY with a processor number of `NUM_CPU` or above responds ERROR (code 5). So does the reserved op 3. Neither changes any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Unit can accept a command |
| cmd_op_i | input | 2 | 0 SEND, 1 WAIT, 2 POP-READY, 3 reserved |
| cmd_idx_i | input | $clog2(NUM_SIG) | Signal index, or processor number for POP-READY |
| cmd_pid_i | input | PID_W | Caller's process id for WAIT |
| rsp_valid_o | output | 1 | Response present |
| rsp_code_o | output | 3 | Response code (see R2 to R11) |
| rsp_pid_o | output | PID_W | Released process id, zero unless code is RELEASED |

## Verification
Commands may follow each other on consecutive edges. The interesting collision is a WAIT that enqueues a process on one edge, followed by a SEND or POP-READY on the very next edge that must already see that entry at the queue head. The bench issues every command back to back with no idle cycle between them. It then judges each response against the arrival order it recorded: releases must come back in enqueue order, and the entry rejected on a full queue must never appear. The same back-to-back pattern also runs a banked send against an immediately following wait, and it drives a counter into saturation and then drains it.

// File: rtl/sig_pkg.sv
package sig_pkg;
  typedef enum logic [1:0] {
    OP_SEND = 2'd0,
    OP_WAIT = 2'd1,
    OP_POP  = 2'd2,
    OP_RSVD = 2'd3
  } sig_op_e;

  typedef enum logic [2:0] {
    RSP_COUNTED  = 3'd0,
    RSP_RELEASED = 3'd1,
    RSP_CONTINUE = 3'd2,
    RSP_BLOCKED  = 3'd3,
    RSP_EMPTY    = 3'd4,
    RSP_ERROR    = 3'd5
  } sig_rsp_e;
endpackage

// File: rtl/sig_queue.sv
module sig_queue #(
  parameter int QDEPTH = 16,
  parameter int PID_W  = 8,
  parameter int CNT_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             inc_i,
  input  logic             dec_i,
  input  logic [PID_W-1:0] pid_i,
  output logic [PID_W-1:0] head_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             cnt_zero_o
);
  localparam int PTR_W = $clog2(QDEPTH);
  localparam int USE_W = PTR_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [PID_W-1:0] mem_q [QDEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [USE_W-1:0] used_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= pid_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      used_q   <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_i)  rd_ptr_q <= rd_ptr_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   used_q <= used_q + 1'b1;
        2'b01:   used_q <= used_q - 1'b1;
        default: used_q <= used_q;
      endcase
    end
  end

  // counter saturates at its maximum, never wraps below zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (inc_i && cnt_q != CNT_MAX)   cnt_q <= cnt_q + 1'b1;
    else if (dec_i && cnt_q != '0)        cnt_q <= cnt_q - 1'b1;
  end

  assign head_o     = mem_q[rd_ptr_q];
  assign empty_o    = (used_q == '0);
  assign full_o     = (used_q == USE_W'(QDEPTH));
  assign cnt_zero_o = (cnt_q == '0);

  p_push_not_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  p_pop_not_empty_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  p_cnt_only_empty_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_zero_o |-> empty_o);
  p_cnt_sat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);
  p_dec_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |=> cnt_q == $past(cnt_q) - 1'b1);
  p_push_grows_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |=> used_q == $past(used_q) + 1'b1);
endmodule

// File: rtl/sig_cmd_dec.sv
module sig_cmd_dec
  import sig_pkg::*;
#(
  parameter int NUM_SIG    = 8,
  parameter int NUM_CPU    = 4,
  parameter int READY_BASE = 4,
  parameter int PID_W      = 8,
  localparam int IDX_W     = $clog2(NUM_SIG)
) (
  input  logic                            accept_i,
  input  logic [1:0]                      op_i,
  input  logic [IDX_W-1:0]                idx_i,
  input  logic [NUM_SIG-1:0]              empty_i,
  input  logic [NUM_SIG-1:0]              full_i,
  input  logic [NUM_SIG-1:0]              cnt_zero_i,
  input  logic [NUM_SIG-1:0][PID_W-1:0]   head_i,
  output logic [NUM_SIG-1:0]              push_o,
  output logic [NUM_SIG-1:0]              pop_o,
  output logic [NUM_SIG-1:0]              inc_o,
  output logic [NUM_SIG-1:0]              dec_o,
  output sig_rsp_e                        code_o,
  output logic [PID_W-1:0]                pid_o
);
  logic [IDX_W-1:0]   sel;
  logic [NUM_SIG-1:0] hit;
  logic               cpu_ok;

  always_comb begin
    push_o = '0;
    pop_o  = '0;
    inc_o  = '0;
    dec_o  = '0;
    code_o = RSP_ERROR;
    pid_o  = '0;
    cpu_ok = ({1'b0, idx_i} < (IDX_W + 1)'(NUM_CPU));
    sel    = (sig_op_e'(op_i) == OP_POP) ? IDX_W'(READY_BASE) + idx_i : idx_i;
    hit    = accept_i ? (NUM_SIG'(1) << sel) : '0;
    case (sig_op_e'(op_i))
      OP_SEND: begin
        if (!empty_i[sel]) begin
          pop_o  = hit;
          code_o = RSP_RELEASED;
          pid_o  = head_i[sel];
        end else begin
          inc_o  = hit;
          code_o = RSP_COUNTED;
        end
      end
      OP_WAIT: begin
        if (!cnt_zero_i[sel]) begin
          dec_o  = hit;
          code_o = RSP_CONTINUE;
        end else if (!full_i[sel]) begin
          push_o = hit;
          code_o = RSP_BLOCKED;
        end
      end
      OP_POP: begin
        if (cpu_ok) begin
          if (!empty_i[sel]) begin
            pop_o  = hit;
            code_o = RSP_RELEASED;
            pid_o  = head_i[sel];
          end else begin
            code_o = RSP_EMPTY;
          end
        end
      end
      default: code_o = RSP_ERROR;
    endcase
  end
endmodule

// File: rtl/sig_unit.sv
module sig_unit
  import sig_pkg::*;
#(
  parameter int NUM_SIG    = 8,
  parameter int QDEPTH     = 16,
  parameter int PID_W      = 8,
  parameter int CNT_W      = 16,
  parameter int NUM_CPU    = 4,
  parameter int READY_BASE = 4,
  localparam int IDX_W     = $clog2(NUM_SIG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic [1:0]       cmd_op_i,
  input  logic [IDX_W-1:0] cmd_idx_i,
  input  logic [PID_W-1:0] cmd_pid_i,
  output logic             rsp_valid_o,
  output logic [2:0]       rsp_code_o,
  output logic [PID_W-1:0] rsp_pid_o
);
  logic                          ready_q, accept;
  logic [NUM_SIG-1:0]            push, pop, inc, dec;
  logic [NUM_SIG-1:0]            empty, full, cnt_zero;
  logic [NUM_SIG-1:0][PID_W-1:0] head;
  sig_rsp_e                      code_d;
  logic [PID_W-1:0]              pid_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ready_q <= 1'b0;
    else         ready_q <= 1'b1;
  end

  assign cmd_ready_o = ready_q;
  assign accept      = cmd_valid_i & ready_q;

  sig_cmd_dec #(
    .NUM_SIG(NUM_SIG), .NUM_CPU(NUM_CPU), .READY_BASE(READY_BASE), .PID_W(PID_W)
  ) u_dec (
    .accept_i   (accept),
    .op_i       (cmd_op_i),
    .idx_i      (cmd_idx_i),
    .empty_i    (empty),
    .full_i     (full),
    .cnt_zero_i (cnt_zero),
    .head_i     (head),
    .push_o     (push),
    .pop_o      (pop),
    .inc_o      (inc),
    .dec_o      (dec),
    .code_o     (code_d),
    .pid_o      (pid_d)
  );

  for (genvar g = 0; g < NUM_SIG; g++) begin : g_sig
    sig_queue #(.QDEPTH(QDEPTH), .PID_W(PID_W), .CNT_W(CNT_W)) u_q (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .push_i     (push[g]),
      .pop_i      (pop[g]),
      .inc_i      (inc[g]),
      .dec_i      (dec[g]),
      .pid_i      (cmd_pid_i),
      .head_o     (head[g]),
      .empty_o    (empty[g]),
      .full_o     (full[g]),
      .cnt_zero_o (cnt_zero[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_code_o  <= '0;
      rsp_pid_o   <= '0;
    end else begin
      rsp_valid_o <= accept;
      if (accept) begin
        rsp_code_o <= code_d;
        rsp_pid_o  <= pid_d;
      end
    end
  end

  p_rsp_next_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> rsp_valid_o);
  p_no_rsp_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> !rsp_valid_o);
  p_single_target_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(push | pop | inc | dec));
  p_release_pid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && pop != '0) |=> (rsp_code_o == 3'(RSP_RELEASED)));
endmodule

// File: tb/tb_sig_unit.sv
`timescale 1ns/1ps
module tb_sig_unit;
  import sig_pkg::*;

  localparam logic [1:0] SEND = 2'd0, WAIT = 2'd1, POP = 2'd2, RSVD = 2'd3;
  localparam int CW = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [1:0] cmd_op = '0;
  logic [2:0] cmd_idx = '0;
  logic [7:0] cmd_pid = '0;
  logic       rsp_valid;
  logic [2:0] rsp_code;
  logic [7:0] rsp_pid;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  sig_unit #(.CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_op_i(cmd_op), .cmd_idx_i(cmd_idx), .cmd_pid_i(cmd_pid),
    .rsp_valid_o(rsp_valid), .rsp_code_o(rsp_code), .rsp_pid_o(rsp_pid)
  );

  // call at a negedge; returns at the next negedge with the response checked
  task automatic issue(input logic [1:0] op, input logic [2:0] idx, input logic [7:0] pid,
                       input logic [2:0] ecode, input logic [7:0] epid, input string tag);
    cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx; cmd_pid = pid;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0;
    n_chk++;
    if (rsp_valid !== 1'b1 || rsp_code !== ecode ||
        (ecode == RSP_RELEASED && rsp_pid !== epid)) begin
      n_bad++;
      $display("FAIL %s: valid=%0b code=%0d pid=%0h expected valid=1 code=%0d pid=%0h",
               tag, rsp_valid, rsp_code, rsp_pid, ecode, epid);
    end
  endtask

  task automatic idle_chk(input string tag);
    @(posedge clk); @(negedge clk);
    n_chk++;
    if (rsp_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL %s: rsp_valid=%0b expected 0", tag, rsp_valid);
    end
  endtask

  task automatic t_reset;
    n_chk++;
    if (cmd_ready !== 1'b1 || rsp_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: ready=%0b valid=%0b expected ready=1 valid=0", cmd_ready, rsp_valid);
    end
    issue(POP, 3'd0, 8'h0, RSP_EMPTY, 8'h0, "R1 empty after reset");
    issue(WAIT, 3'd0, 8'h05, RSP_BLOCKED, 8'h0, "R1 zero count after reset");
    issue(SEND, 3'd0, 8'h0, RSP_RELEASED, 8'h05, "R2 release reset probe");
  endtask

  task automatic t_count;
    for (int i = 0; i < 3; i++) issue(SEND, 3'd1, 8'h0, RSP_COUNTED, 8'h0, "R3 banked send");
    for (int i = 0; i < 3; i++) issue(WAIT, 3'd1, 8'h0, RSP_CONTINUE, 8'h0, "R4 consume count");
    issue(WAIT, 3'd1, 8'h09, RSP_BLOCKED, 8'h0, "R5 block when count zero");
    issue(SEND, 3'd1, 8'h0, RSP_RELEASED, 8'h09, "R2 release blocked");
  endtask

  task automatic t_order;
    for (int i = 0; i < 3; i++)
      issue(WAIT, 3'd2, 8'(8'h10 + i), RSP_BLOCKED, 8'h0, "R5 enqueue");
    for (int i = 0; i < 3; i++)
      issue(SEND, 3'd2, 8'h0, RSP_RELEASED, 8'(8'h10 + i), "R2 arrival order");
    issue(SEND, 3'd2, 8'h0, RSP_COUNTED, 8'h0, "R3 after drain");
    issue(WAIT, 3'd2, 8'h0, RSP_CONTINUE, 8'h0, "R4 after drain");
  endtask

  task automatic t_full;
    for (int i = 0; i < 16; i++)
      issue(WAIT, 3'd3, 8'(8'h20 + i), RSP_BLOCKED, 8'h0, "R5 fill");
    issue(WAIT, 3'd3, 8'h99, RSP_ERROR, 8'h0, "R7 full queue");
    for (int i = 0; i < 16; i++)
      issue(SEND, 3'd3, 8'h0, RSP_RELEASED, 8'(8'h20 + i), "R7 contents intact");
    issue(SEND, 3'd3, 8'h0, RSP_COUNTED, 8'h0, "R7 rejected id absent");
    issue(WAIT, 3'd3, 8'h0, RSP_CONTINUE, 8'h0, "R4 cleanup");
  endtask

  task automatic t_ready;
    issue(WAIT, 3'd5, 8'h41, RSP_BLOCKED, 8'h0, "R6 ready enqueue");
    issue(WAIT, 3'd5, 8'h42, RSP_BLOCKED, 8'h0, "R6 ready enqueue");
    issue(POP, 3'd1, 8'h0, RSP_RELEASED, 8'h41, "R6 pop first");
    issue(POP, 3'd1, 8'h0, RSP_RELEASED, 8'h42, "R6 pop second");
    issue(POP, 3'd1, 8'h0, RSP_EMPTY, 8'h0, "R6 pop empty");
    issue(POP, 3'd4, 8'h0, RSP_ERROR, 8'h0, "R11 cpu out of range");
    issue(RSVD, 3'd2, 8'h0, RSP_ERROR, 8'h0, "R11 reserved op");
    issue(SEND, 3'd6, 8'h0, RSP_COUNTED, 8'h0, "R6 bank on ready signal");
    issue(POP, 3'd2, 8'h0, RSP_EMPTY, 8'h0, "R6 pop ignores count");
    issue(WAIT, 3'd6, 8'h0, RSP_CONTINUE, 8'h0, "R6 count survived pop");
    issue(WAIT, 3'd6, 8'h61, RSP_BLOCKED, 8'h0, "R6 count was one");
    issue(POP, 3'd2, 8'h0, RSP_RELEASED, 8'h61, "R6 pop cleanup");
    issue(SEND, 3'd2, 8'h0, RSP_COUNTED, 8'h0, "R11 reserved op left sig2");
    issue(WAIT, 3'd2, 8'h0, RSP_CONTINUE, 8'h0, "R11 cleanup");
  endtask

  task automatic t_sat;
    for (int i = 0; i < (1 << CW); i++) issue(SEND, 3'd0, 8'h0, RSP_COUNTED, 8'h0, "R8 fill count");
    for (int i = 0; i < (1 << CW) - 1; i++) issue(WAIT, 3'd0, 8'h0, RSP_CONTINUE, 8'h0, "R8 drain count");
    issue(WAIT, 3'd0, 8'h77, RSP_BLOCKED, 8'h0, "R8 saturated at max");
    issue(SEND, 3'd0, 8'h0, RSP_RELEASED, 8'h77, "R8 cleanup");
  endtask

  task automatic t_indep;
    issue(SEND, 3'd1, 8'h0, RSP_COUNTED, 8'h0, "R10 bank sig1");
    issue(SEND, 3'd1, 8'h0, RSP_COUNTED, 8'h0, "R10 bank sig1");
    issue(WAIT, 3'd2, 8'h03, RSP_BLOCKED, 8'h0, "R10 sig2 unaffected");
    issue(WAIT, 3'd1, 8'h0, RSP_CONTINUE, 8'h0, "R10 sig1 count");
    issue(WAIT, 3'd1, 8'h0, RSP_CONTINUE, 8'h0, "R10 sig1 count");
    issue(SEND, 3'd2, 8'h0, RSP_RELEASED, 8'h03, "R10 sig2 queue");
  endtask

  task automatic t_idle;
    idle_chk("R9 no response without command");
    cmd_op = SEND; cmd_idx = 3'd7; cmd_valid = 1'b0;
    idle_chk("R9 invalid command ignored");
    issue(WAIT, 3'd7, 8'h01, RSP_BLOCKED, 8'h0, "R9 unaccepted send not banked");
    issue(POP, 3'd3, 8'h0, RSP_RELEASED, 8'h01, "R9 cleanup");
    idle_chk("R9 valid drops after response");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R9 watchdog: actual=hang expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_order();
    t_full();
    t_ready();
    t_sat();
    t_indep();
    t_idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule